// File: doc/BRIEF.md
# Request Batch Marker for a Shared Memory Scheduler

This block holds the pending requests of a shared memory controller and decides which of them belong to the current batch. Each slot stores the issuing thread, the target bank, the row address, an arrival stamp and one mark bit. The set of marked slots is the batch. Downstream ranking and arbitration logic grants marked slots ahead of unmarked ones.

When no slot is marked and at least one slot holds a request, the block starts a new batch. Before the scan it takes a snapshot of the occupied slots and latches the per-class cap. It then scans the buffer one slot per cycle. A slot is marked when fewer than cap snapshot slots of the same thread and bank are older than it. Because of this rule, each (thread, bank) class contributes at most cap of its oldest requests. After the last slot has been scanned, the block raises a one-cycle batch-formed pulse.

A granted slot leaves the buffer and loses its mark. Requests that arrive after the snapshot stay unmarked until a later batch. A new batch is never started while any mark remains, so batches do not overlap.

The controller has three states. WAIT_DRAIN holds while a batch is active or the buffer is empty; it goes to SCAN once no mark remains and some slot is valid. SCAN advances one slot per cycle; it goes to ANNOUNCE after the last slot. ANNOUNCE drives the pulse for one cycle and always returns to WAIT_DRAIN.

Top module: `batch_marker`

## Requirements
- R1: After reset every slot is empty and unmarked, `buf_full` is 0 and `batch_formed` is 0.
- R2: A request with `req_valid` high while `buf_full` is low is written into the lowest-numbered empty slot and shows in `valid_vec` at the next edge. The slot's thread, bank and row appear in `ent_thread`, `ent_bank` and `ent_row` at bit offsets slot*width. `buf_full` is high exactly when every slot is valid, and a request offered while it is high is dropped.
- R3: At batch formation, each (thread, bank) class marks its oldest snapshot requests, min(cap, class size) of them. Age is arrival order, independent of slot number.
- R4: `batch_formed` is high for exactly one cycle. That cycle is DEPTH+1 cycles after the cycle in which the formation condition held, and the new marks are visible in it.
- R5: A batch starts only in WAIT_DRAIN, with no mark set and at least one valid slot. With an empty buffer no pulse is ever produced.
- R6: A request accepted after the snapshot cycle is not marked by the scan in progress. It is not marked before the next batch either.
- R7: `grant_valid` with index `grant_idx` clears that slot's valid and mark bits at the next edge. A grant to an empty slot changes nothing.
- R8: `mark_cap` is sampled in the cycle the scan is started. Changes during the scan have no effect, and a cap of 0 marks nothing.
- R9: Arrival stamps wrap around. Ordering stays correct while the live requests span fewer than 2^(AGE_W-1) arrivals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | New request offered |
| req_thread | input | TID_W | Issuing thread of the new request |
| req_bank | input | BANK_W | Target bank of the new request |
| req_row | input | ROW_W | Row address of the new request |
| mark_cap | input | CAP_W | Per-thread, per-bank mark limit |
| grant_valid | input | 1 | Service grant strobe |
| grant_idx | input | IDX_W | Slot being serviced |
| buf_full | output | 1 | Every slot is occupied |
| valid_vec | output | DEPTH | Slot occupancy |
| mark_vec | output | DEPTH | Slot mark bits (current batch) |
| batch_formed | output | 1 | One-cycle pulse at the end of a marking scan |
| ent_thread | output | DEPTH*TID_W | Thread field of every slot |
| ent_bank | output | DEPTH*BANK_W | Bank field of every slot |
| ent_row | output | DEPTH*ROW_W | Row field of every slot |

## Verification
The bench builds the block with 8 slots, 4 threads, 2 banks and a 6-bit arrival stamp. With these values a full buffer, the drop of a request offered while full, and a full 8-cycle scan all happen within a few cycles. The stamp wraps several times during the randomized rounds, so ordering across the wrap is exercised. Small caps of 0 to 3 make several same-class requests compete for a limited number of marks.

// File: rtl/batch_pkg.sv
package batch_pkg;
    typedef enum logic [1:0] {
        ST_WAIT_DRAIN = 2'd0,
        ST_SCAN       = 2'd1,
        ST_ANNOUNCE   = 2'd2
    } bm_state_e;
endpackage

// File: rtl/batch_entry_store.sv
module batch_entry_store #(
    parameter int DEPTH  = 128,
    parameter int TID_W  = 2,
    parameter int BANK_W = 3,
    parameter int ROW_W  = 14,
    parameter int AGE_W  = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [TID_W-1:0]        req_thread,
    input  logic [BANK_W-1:0]       req_bank,
    input  logic [ROW_W-1:0]        req_row,
    input  logic                    grant_valid,
    input  logic [IDX_W-1:0]        grant_idx,
    output logic                    full,
    output logic [DEPTH-1:0]        valid_vec,
    output logic [DEPTH*TID_W-1:0]  thread_flat,
    output logic [DEPTH*BANK_W-1:0] bank_flat,
    output logic [DEPTH*ROW_W-1:0]  row_flat,
    output logic [DEPTH*AGE_W-1:0]  age_flat
);
    logic [DEPTH-1:0] valid_q;
    logic [IDX_W-1:0] free_slot;
    logic             free_found;
    logic             enq_fire;
    logic [AGE_W-1:0] stamp_q;

    always_comb begin
        free_found = 1'b0;
        free_slot  = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!valid_q[i]) begin
                free_found = 1'b1;
                free_slot  = IDX_W'(i);
            end
        end
    end

    assign enq_fire  = req_valid && free_found;
    assign full      = !free_found;
    assign valid_vec = valid_q;

    always_ff @(posedge clk) begin
        if (!rst_n)        stamp_q <= '0;
        else if (enq_fire) stamp_q <= stamp_q + 1'b1;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                valid_q[g] <= 1'b0;
            else if (enq_fire && free_slot == IDX_W'(g))
                valid_q[g] <= 1'b1;
            else if (grant_valid && grant_idx == IDX_W'(g))
                valid_q[g] <= 1'b0;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                thread_flat[g*TID_W +: TID_W]  <= '0;
                bank_flat[g*BANK_W +: BANK_W]  <= '0;
                row_flat[g*ROW_W +: ROW_W]     <= '0;
                age_flat[g*AGE_W +: AGE_W]     <= '0;
            end else if (enq_fire && free_slot == IDX_W'(g)) begin
                thread_flat[g*TID_W +: TID_W]  <= req_thread;
                bank_flat[g*BANK_W +: BANK_W]  <= req_bank;
                row_flat[g*ROW_W +: ROW_W]     <= req_row;
                age_flat[g*AGE_W +: AGE_W]     <= stamp_q;
            end
        end
    end

    AST_GRANT_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && valid_q[grant_idx]) |=> !valid_q[$past(grant_idx)]); // R7

    AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !grant_valid) |=> (valid_q == $past(valid_q))); // R2
endmodule

// File: rtl/batch_mark_eval.sv
module batch_mark_eval #(
    parameter int DEPTH  = 128,
    parameter int TID_W  = 2,
    parameter int BANK_W = 3,
    parameter int AGE_W  = 16,
    parameter int CAP_W  = 4,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [IDX_W-1:0]        idx,
    input  logic [DEPTH-1:0]        cand,
    input  logic [DEPTH*TID_W-1:0]  thread_flat,
    input  logic [DEPTH*BANK_W-1:0] bank_flat,
    input  logic [DEPTH*AGE_W-1:0]  age_flat,
    input  logic [CAP_W-1:0]        cap,
    output logic                    take
);
    logic [TID_W-1:0]  my_tid;
    logic [BANK_W-1:0] my_bank;
    logic [AGE_W-1:0]  my_age;
    logic [AGE_W-1:0]  diff;
    logic [CNT_W-1:0]  older_cnt;

    always_comb begin
        my_tid    = thread_flat[idx*TID_W +: TID_W];
        my_bank   = bank_flat[idx*BANK_W +: BANK_W];
        my_age    = age_flat[idx*AGE_W +: AGE_W];
        older_cnt = '0;
        diff      = '0;
        for (int j = 0; j < DEPTH; j++) begin
            diff = age_flat[j*AGE_W +: AGE_W] - my_age;
            if (cand[j] && IDX_W'(j) != idx
                && thread_flat[j*TID_W +: TID_W] == my_tid
                && bank_flat[j*BANK_W +: BANK_W] == my_bank
                && diff[AGE_W-1])
                older_cnt = older_cnt + 1'b1;
        end
        take = cand[idx] && ({{(CNT_W + CAP_W){1'b0}}, older_cnt} < {{CNT_W{1'b0}}, {CNT_W{1'b0}}, cap});
    end
endmodule

// File: rtl/batch_marker.sv
module batch_marker #(
    parameter int DEPTH       = 128,
    parameter int NUM_THREADS = 4,
    parameter int NUM_BANKS   = 8,
    parameter int ROW_W       = 14,
    parameter int AGE_W       = 16,
    parameter int CAP_W       = 4,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int TID_W  = $clog2(NUM_THREADS),
    localparam int BANK_W = $clog2(NUM_BANKS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [TID_W-1:0]        req_thread,
    input  logic [BANK_W-1:0]       req_bank,
    input  logic [ROW_W-1:0]        req_row,
    input  logic [CAP_W-1:0]        mark_cap,
    input  logic                    grant_valid,
    input  logic [IDX_W-1:0]        grant_idx,
    output logic                    buf_full,
    output logic [DEPTH-1:0]        valid_vec,
    output logic [DEPTH-1:0]        mark_vec,
    output logic                    batch_formed,
    output logic [DEPTH*TID_W-1:0]  ent_thread,
    output logic [DEPTH*BANK_W-1:0] ent_bank,
    output logic [DEPTH*ROW_W-1:0]  ent_row
);
    import batch_pkg::*;

    bm_state_e              state_q, state_d;
    logic [IDX_W-1:0]       ptr_q;
    logic [DEPTH-1:0]       cand_q;
    logic [DEPTH-1:0]       mark_q;
    logic [CAP_W-1:0]       cap_q;
    logic [DEPTH-1:0]       gmask;
    logic [DEPTH*AGE_W-1:0] age_flat;
    logic                   take;
    logic                   start_scan;

    batch_entry_store #(
        .DEPTH(DEPTH), .TID_W(TID_W), .BANK_W(BANK_W), .ROW_W(ROW_W), .AGE_W(AGE_W)
    ) store_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_thread(req_thread), .req_bank(req_bank), .req_row(req_row),
        .grant_valid(grant_valid), .grant_idx(grant_idx),
        .full(buf_full), .valid_vec(valid_vec),
        .thread_flat(ent_thread), .bank_flat(ent_bank), .row_flat(ent_row), .age_flat(age_flat)
    );

    batch_mark_eval #(
        .DEPTH(DEPTH), .TID_W(TID_W), .BANK_W(BANK_W), .AGE_W(AGE_W), .CAP_W(CAP_W)
    ) eval_i (
        .idx(ptr_q), .cand(cand_q), .thread_flat(ent_thread), .bank_flat(ent_bank),
        .age_flat(age_flat), .cap(cap_q), .take(take)
    );

    assign gmask = grant_valid ? (DEPTH'(1) << grant_idx) : '0;

    // next-state selection
    always_comb begin
        state_d    = state_q;
        start_scan = 1'b0;
        unique case (state_q)
            ST_WAIT_DRAIN: begin
                if (!(|mark_q) && (|valid_vec)) begin
                    state_d    = ST_SCAN;
                    start_scan = 1'b1;
                end
            end
            ST_SCAN: begin
                if (ptr_q == IDX_W'(DEPTH - 1)) state_d = ST_ANNOUNCE;
            end
            ST_ANNOUNCE: state_d = ST_WAIT_DRAIN;
            default:     state_d = ST_WAIT_DRAIN;
        endcase
    end

    // state register and scan bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WAIT_DRAIN;
            ptr_q   <= '0;
            cand_q  <= '0;
            mark_q  <= '0;
            cap_q   <= '0;
        end else begin
            state_q <= state_d;
            if (start_scan) begin
                ptr_q  <= '0;
                cand_q <= valid_vec & ~gmask;
                cap_q  <= mark_cap;
            end else begin
                cand_q <= cand_q & ~gmask;
                if (state_q == ST_SCAN) ptr_q <= ptr_q + 1'b1;
            end
            if (state_q == ST_SCAN && take && !gmask[ptr_q])
                mark_q <= (mark_q & ~gmask) | (DEPTH'(1) << ptr_q);
            else
                mark_q <= mark_q & ~gmask;
        end
    end

    // outputs
    always_comb begin
        batch_formed = (state_q == ST_ANNOUNCE);
        mark_vec     = mark_q;
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        batch_formed |=> !batch_formed); // R4

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_DRAIN && (|mark_q)) |=> (state_q == ST_WAIT_DRAIN)); // R5

    AST_MARK_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        ((mark_q & ~valid_vec) == '0)); // R7

    AST_MARK_ONLY_IN_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        ((mark_q & ~$past(mark_q)) != '0) |-> ($past(state_q) == ST_SCAN)); // R6
endmodule

// File: tb/batch_marker_tb_top.sv
module batch_marker_tb_top;
    localparam int DEPTH = 8;
    localparam int NTH   = 4;
    localparam int NBK   = 2;
    localparam int ROW_W = 4;
    localparam int AGE_W = 6;
    localparam int CAP_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_thread = '0;
    logic [0:0] req_bank = '0;
    logic [ROW_W-1:0] req_row = '0;
    logic [CAP_W-1:0] mark_cap = 4'd2;
    logic grant_valid = 1'b0;
    logic [2:0] grant_idx = '0;
    logic buf_full;
    logic [DEPTH-1:0] valid_vec, mark_vec;
    logic batch_formed;
    logic [DEPTH*2-1:0] ent_thread;
    logic [DEPTH-1:0] ent_bank;
    logic [DEPTH*ROW_W-1:0] ent_row;

    int tests = 0;
    int fails = 0;
    int pulses = 0;
    bit done = 0;

    always #5 clk = ~clk;

    batch_marker #(.DEPTH(DEPTH), .NUM_THREADS(NTH), .NUM_BANKS(NBK), .ROW_W(ROW_W),
                   .AGE_W(AGE_W), .CAP_W(CAP_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_thread(req_thread),
        .req_bank(req_bank), .req_row(req_row), .mark_cap(mark_cap),
        .grant_valid(grant_valid), .grant_idx(grant_idx), .buf_full(buf_full),
        .valid_vec(valid_vec), .mark_vec(mark_vec), .batch_formed(batch_formed),
        .ent_thread(ent_thread), .ent_bank(ent_bank), .ent_row(ent_row));

    // behavioural reference model
    logic [DEPTH-1:0] m_valid, m_mark, m_cand;
    int m_tid[DEPTH];
    int m_bank[DEPTH];
    int m_seq[DEPTH];
    int m_state, m_ptr, m_cap, seqn;
    int slot, cnt, gi;
    bit take, go;

    always @(posedge clk) begin
        if (batch_formed && rst_n) pulses++;
        if (!rst_n) begin
            m_valid = '0; m_mark = '0; m_cand = '0;
            m_state = 0; m_ptr = 0; m_cap = 0; seqn = 0;
        end else begin
            gi = int'(grant_idx);
            slot = -1;
            if (req_valid && !(&m_valid))
                for (int i = DEPTH - 1; i >= 0; i--) if (!m_valid[i]) slot = i;
            take = 0;
            if (m_state == 1) begin
                cnt = 0;
                for (int j = 0; j < DEPTH; j++)
                    if (m_cand[j] && j != m_ptr && m_tid[j] == m_tid[m_ptr]
                        && m_bank[j] == m_bank[m_ptr] && m_seq[j] < m_seq[m_ptr]) cnt++;
                take = m_cand[m_ptr] && cnt < m_cap && !(grant_valid && gi == m_ptr);
            end
            go = (m_state == 0) && (m_mark == '0) && (m_valid != '0);
            if (take) m_mark[m_ptr] = 1'b1;
            case (m_state)
                0: if (go) begin m_state = 1; m_ptr = 0; m_cand = m_valid; m_cap = int'(mark_cap); end
                1: begin if (m_ptr == DEPTH - 1) m_state = 2; m_ptr++; end
                default: m_state = 0;
            endcase
            if (grant_valid) begin m_valid[gi] = 0; m_mark[gi] = 0; m_cand[gi] = 0; end
            if (slot >= 0) begin
                m_valid[slot] = 1; m_seq[slot] = seqn++;
                m_tid[slot] = int'(req_thread); m_bank[slot] = int'(req_bank);
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            tests++;
            if (valid_vec !== m_valid) begin fails++;
                $display("FAIL R2 valid_vec act=%b exp=%b", valid_vec, m_valid); end
            tests++;
            if (buf_full !== (&m_valid)) begin fails++;
                $display("FAIL R2 buf_full act=%b exp=%b", buf_full, &m_valid); end
            tests++;
            if (mark_vec !== m_mark) begin fails++;
                $display("FAIL R3 mark_vec act=%b exp=%b", mark_vec, m_mark); end
            tests++;
            if (batch_formed !== (m_state == 2)) begin fails++;
                $display("FAIL R4 batch_formed act=%b exp=%b", batch_formed, m_state == 2); end
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic enq(int t, int b, int r);
        req_valid = 1; req_thread = 2'(t); req_bank = 1'(b); req_row = ROW_W'(r);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic grant(int idx);
        grant_valid = 1; grant_idx = 3'(idx);
        @(negedge clk);
        grant_valid = 0;
    endtask

    task automatic wait_pulse(string tag);
        bit seen;
        seen = 0;
        for (int k = 0; k < 40 && !seen; k++) begin
            if (batch_formed) seen = 1; else @(negedge clk);
        end
        check(tag, 32'(seen), 32'd1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        check("R1 valid", 32'(valid_vec), 0);
        check("R1 mark", 32'(mark_vec), 0);
        check("R1 full", 32'(buf_full), 0);
        check("R1 pulse", 32'(batch_formed), 0);
        // R5: empty buffer never forms a batch
        repeat (20) @(negedge clk);
        check("R5 pulses on empty", pulses, 0);

        enq(0, 0, 5);
        check("R2 row of slot0", 32'(ent_row[3:0]), 5);
        wait_pulse("R4 first batch");
        check("R3 single entry marked", 32'(mark_vec), 32'h01);
        // arrivals while batch active
        enq(0, 0, 1); enq(0, 0, 2); enq(0, 0, 3); enq(1, 1, 4); enq(2, 0, 6);
        check("R6 late arrivals unmarked", 32'(mark_vec), 32'h01);
        check("R2 slot4 thread", 32'(ent_thread[9:8]), 1);
        grant(0);
        wait_pulse("R4 second batch");
        check("R3 cap two per class", 32'(mark_vec), 32'h36);
        grant(7);
        check("R7 grant to empty slot ignored", 32'(valid_vec), 32'h3E);
        grant(2);
        check("R7 grant clears valid", 32'(valid_vec), 32'h3A);
        check("R7 grant clears mark", 32'(mark_vec), 32'h32);
        enq(0, 0, 9);
        check("R6 new slot0 not marked", 32'(mark_vec), 32'h32);
        grant(1); grant(4);
        mark_cap = 4'd1;
        grant(5);
        @(negedge clk);
        mark_cap = 4'd15;   // R8: change during scan must not matter
        wait_pulse("R4 third batch");
        check("R8 cap latched, R3 age not index", 32'(mark_vec), 32'h08);
        grant(3);
        wait_pulse("R4 fourth batch");
        check("R3 slot0 marked now", 32'(mark_vec), 32'h01);
        grant(0);
        // fill buffer, then offer one more
        for (int i = 0; i < DEPTH; i++) enq(i % 4, i % 2, i);
        check("R2 full flag", 32'(buf_full), 1);
        enq(3, 1, 15);
        check("R2 drop while full", 32'(valid_vec), 32'hFF);
        for (int i = 0; i < DEPTH; i++) grant(i);
        repeat (12) @(negedge clk);
        check("R7 drained", 32'(valid_vec), 0);
        // randomized rounds; stamps wrap (R9)
        for (int r = 0; r < 14; r++) begin
            for (int c = 0; c < 28; c++) begin
                req_valid = ($urandom % 2) == 0;
                req_thread = 2'($urandom);
                req_bank = 1'($urandom);
                req_row = ROW_W'($urandom);
                grant_valid = ($urandom % 5) < 2;
                grant_idx = 3'($urandom);
                mark_cap = CAP_W'($urandom % 4);
                @(negedge clk);
            end
            req_valid = 0;
            for (int c = 0; c < 60 && valid_vec != 0; c++) begin
                grant_valid = 1; grant_idx = 3'(c % DEPTH);
                @(negedge clk);
            end
            grant_valid = 0;
            check("R9 round drained", 32'(valid_vec), 0);
        end
        repeat (12) @(negedge clk);
        finish_run();
    end
endmodule